// File: doc/BRIEF.md
# Peripheral Interrupt Aggregation Controller

The controller gathers event pulses from nine engine sources and merges them into one active-low interrupt line for a host processor. Each source event is latched into a pending bit. A per-source enable decides whether that pending bit can drive the merged line. The host reads the pending bits through a 16-bit register port and acknowledges them by writing ones to a separate clear register.

Bit 9 of the enable register is a master gate. While it is one, the interrupt line stays high whatever is pending. The usual running value of the enable register is 0x01FF. The output is registered, so the host's falling-edge detector never sees a glitch. Because the status register shows every pending source at once, the host can service several sources in one pass.

The register port uses a 2-bit word address. Address 0 is status and is read-only. Address 1 is enable and is read-write. Address 2 is clear, is write-only and reads as zero. Address 3 is unused and reads as zero. A read returns its data on `bus_rdata` one clock after `bus_rd` is sampled high, and `bus_rdata` keeps that value until the next read.

Top module: `irq_aggr_ctrl`

## Requirements
- R1: After a synchronous reset, the status and enable registers read zero and `irq_n` is high.
- R2: A high `src_evt[n]` in a cycle sets status bit n at that clock edge, whether or not enable bit n is set.
- R3: A write to address 2 clears each status bit n whose data bit n is one. Status bits whose data bit is zero are unchanged.
- R4: When a source event and a clear of the same bit happen in the same cycle, the status bit ends up set.
- R5: Enable bits 9:0 are stored from a write to address 1 and read back from address 1. Bits 15:10 read as zero.
- R6: `irq_n` is low one clock after a cycle in which some status bit and its enable bit are both one and enable bit 9 is zero.
- R7: `irq_n` is high one clock after any cycle in which enable bit 9 is one.
- R8: `irq_n` is high one clock after a cycle in which no pending source is enabled. Masked pending sources do not assert it.
- R9: A read of address 0 returns all pending sources together in bits 8:0, with bits 15:9 zero.
- R10: Read data appears on `bus_rdata` one clock after the read. Reads of address 2 and address 3 return zero.
- R11: A write to address 0 has no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 9 | Event requests, one bit per engine source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_n | output | 1 | Merged active-low interrupt |

## Verification
The bench aims at a clear write that lands in the same cycle as a fresh event on the same source. A design that lets the clear win would lose that event, and status would read zero instead of set. It also toggles the master gate bit 9 while an enabled source is pending. A design that decoded bit 9 with the wrong polarity, or ignored it, would hold `irq_n` low when it should be released. Further checks cover masked sources, which must not pull the line low although they still show in status, and writes to the read-only status address, which a sloppy address decode would turn into a clear or a set.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  parameter int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqa_pending.sv
module irqa_pending #(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);
  // One latch per source; a new event outranks a clear in the same cycle.
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        pend[i] <= 1'b0;
      else if (evt[i])
        pend[i] <= 1'b1;
      else if (clr_we && clr_mask[i])
        pend[i] <= 1'b0;
    end
  end

  // R2 / R4: every event is captured, even if it collides with a clear
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(evt)) == $past(evt)));

  // R3: cleared bits without a new event drop
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((pend & $past(clr_mask & ~evt)) == '0));
endmodule

// File: rtl/irqa_regs.sv
module irqa_regs
  import irqa_pkg::*;
#(
  parameter int unsigned N  = 9,
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [N-1:0]      pend,
  output logic [N:0]        en_q,
  output logic              clr_we,
  output logic [DW-1:0]     rdata
);
  localparam int unsigned EN_W = N + 1;

  reg_sel_e     sel;
  logic [DW-1:0] rd_mux;
  logic          unused_wbits;

  assign sel          = reg_sel_e'(addr);
  assign clr_we       = wr && (sel == SEL_CLEAR);
  assign unused_wbits = ^wdata[DW-1:EN_W];

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (wr && sel == SEL_ENABLE)
      en_q <= wdata[EN_W-1:0];
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_mux = {{(DW-N){1'b0}}, pend};
      SEL_ENABLE: rd_mux = {{(DW-EN_W){1'b0}}, en_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= rd_mux;
  end

  // R10: clear and spare addresses read as zero
  p_rd_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && addr[1]) |=> (rdata == '0));

  // R5: enable holds unless written at its address
  p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == SEL_ENABLE) |=> $stable(en_q));
endmodule

// File: rtl/irqa_irq_out.sv
module irqa_irq_out #(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  input  logic [N:0]   en,
  output logic         irq_n
);
  logic any_req;
  logic gated;

  assign gated   = en[N];
  assign any_req = |(pend & en[N-1:0]);

  always_ff @(posedge clk) begin
    if (rst)
      irq_n <= 1'b1;
    else
      irq_n <= ~(any_req & ~gated);
  end

  // R6: enabled pending source with open gate pulls the line low
  p_assert_r6: assert property (@(posedge clk) disable iff (rst)
    ((|(pend & en[N-1:0])) && !en[N]) |=> !irq_n);

  // R7: master gate forces the line high
  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    en[N] |=> irq_n);

  // R8: nothing enabled and pending keeps the line high
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ((pend & en[N-1:0]) == '0) |=> irq_n);
endmodule

// File: rtl/irq_aggr_ctrl.sv
module irq_aggr_ctrl
  import irqa_pkg::*;
#(
  parameter int unsigned NUM_SRC = 9,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_evt,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_n
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC:0]   en_q;
  logic               clr_we;

  irqa_pending #(.N(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .evt      (src_evt),
    .clr_we   (clr_we),
    .clr_mask (bus_wdata[NUM_SRC-1:0]),
    .pend     (pend)
  );

  irqa_regs #(.N(NUM_SRC), .DW(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .pend   (pend),
    .en_q   (en_q),
    .clr_we (clr_we),
    .rdata  (bus_rdata)
  );

  irqa_irq_out #(.N(NUM_SRC)) u_out (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend),
    .en    (en_q),
    .irq_n (irq_n)
  );

  // R11: a status-address write with no event leaves status unchanged
  p_ro_status_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == SEL_STATUS && src_evt == '0) |=> $stable(pend));
endmodule

// File: tb/irq_aggr_ctrl_tb_top.sv
module irq_aggr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  src_evt;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [8:0] m_stat = '0;
  logic [9:0] m_en = '0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #10 clk = ~clk;

  irq_aggr_ctrl dut_i (
    .clk(clk), .rst(rst), .src_evt(src_evt), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  // monitor: compare read data one cycle after each read
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic drive(input logic w, input logic [1:0] a, input logic [15:0] d,
                       input logic [8:0] e);
    bus_wr = w; bus_addr = a; bus_wdata = d; src_evt = e;
    @(negedge clk);
    bus_wr = 1'b0; src_evt = '0;
    if (w && a == 2'd2) m_stat = m_stat & ~d[8:0];
    m_stat = m_stat | e;
    if (w && a == 2'd1) m_en = d[9:0];
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic irq_chk(input string t);
    logic e;
    @(negedge clk);
    e = ~((|(m_stat & m_en[8:0])) && !m_en[9]);
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s: irq_n=%b expected=%b", t, irq_n, e);
    end
  endtask

  initial begin
    rst = 1'b1; src_evt = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (irq_n !== 1'b1) begin errors++; $display("FAIL R1: irq_n=%b expected=1", irq_n); end
    rd_chk(2'd0, 16'h0000, "R1 status");
    rd_chk(2'd1, 16'h0000, "R1 enable");
    // event while masked
    drive(0, 2'd0, 16'h0, 9'h008);
    rd_chk(2'd0, {7'b0, m_stat}, "R2 masked event latched");
    irq_chk("R8 masked pending");
    // enable it
    drive(1, 2'd1, 16'h0008, '0);
    rd_chk(2'd1, {6'b0, m_en}, "R5 enable readback");
    irq_chk("R6 asserted");
    // master gate
    drive(1, 2'd1, 16'h0208, '0);
    irq_chk("R7 gate high");
    drive(1, 2'd1, 16'h01FF, '0);
    irq_chk("R6 gate reopened");
    // several sources
    drive(0, 2'd0, 16'h0, 9'h101);
    rd_chk(2'd0, {7'b0, m_stat}, "R9 multiple pending");
    drive(1, 2'd2, 16'h0001, '0);
    rd_chk(2'd0, {7'b0, m_stat}, "R3 partial clear");
    // collision of clear and event
    drive(1, 2'd2, 16'h0100, 9'h100);
    rd_chk(2'd0, {7'b0, m_stat}, "R4 event beats clear");
    drive(1, 2'd2, 16'h0108, '0);
    rd_chk(2'd0, 16'h0000, "R3 all cleared");
    irq_chk("R8 nothing pending");
    // write to status is ignored
    drive(1, 2'd0, 16'hFFFF, '0);
    rd_chk(2'd0, 16'h0000, "R11 status write ignored");
    drive(0, 2'd0, 16'h0, 9'h010);
    drive(1, 2'd0, 16'h0000, '0);
    rd_chk(2'd0, 16'h0010, "R11 status write no clear");
    drive(1, 2'd2, 16'h0010, '0);
    drive(1, 2'd1, 16'hFFFF, '0);
    rd_chk(2'd1, 16'h03FF, "R5 upper bits zero");
    irq_chk("R7 gate with all enabled");
    rd_chk(2'd2, 16'h0000, "R10 clear address reads zero");
    rd_chk(2'd3, 16'h0000, "R10 spare address reads zero");
    // partial mask
    drive(1, 2'd1, 16'h00FE, '0);
    drive(0, 2'd0, 16'h0, 9'h001);
    irq_chk("R8 masked source0");
    rd_chk(2'd0, 16'h0001, "R2 status despite mask");
    drive(0, 2'd0, 16'h0, 9'h002);
    irq_chk("R6 enabled source1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule